// File: doc/BRIEF.md
# Predicated Gather Prefetch Address Generator

This block turns one decoded gather-prefetch command into a series of prefetch requests, one for each active element of an index vector. The command gives the element width (32 or 64 bits), the offset mode (a 32-bit offset that is zero- or sign-extended, or a full 64-bit unsigned offset), a 4-bit prefetch hint, the number of the base register, and a per-slot predicate mask. The block first checks whether any element is active. Only if one is, it raises `opnd_rd` for one cycle and captures the scalar base and the index vector from its operand inputs. It then visits the elements in order. For each active element it presents a request on a valid/ready port. The request carries the address `base + (index << 2)`, taken modulo 2^64, and the decoded hint: read or write, cache level, and streaming.

The controller is a five-state machine. IDLE waits for `cmd_start`. CHECK decides whether any element is active. READ strobes the operand read. WALK visits the elements. FIN raises `done` for one cycle. The transitions are:
- IDLE→CHECK on start.
- CHECK→READ when at least one element is active.
- CHECK→FIN when none is active.
- READ→WALK always.
- WALK→WALK while elements remain.
- WALK→FIN once the last element has been handled.
- FIN→IDLE always.

Top module: `gather_pf_agen`

## Requirements
- R1: The address of each request equals the captured base plus the extended index multiplied by 4, wrapping modulo 2^64.
- R2: With 32-bit offsets, only bits 31:0 of the index element are used. They are zero-extended when `cmd_sext` is 0 and sign-extended when it is 1.
- R3: With 64-bit elements and `cmd_off64`=1, the full 64-bit index is used unsigned. With 32-bit elements, `cmd_off64` has no effect.
- R4: With 32-bit elements there are VLEN/32 elements, and element e occupies vector bits 32e+31:32e. With 64-bit elements there are VLEN/64 elements, element e occupies bits 64e+63:64e, and element e is governed by predicate bit 2e. The odd predicate bits are then ignored.
- R5: An element whose governing predicate bit is 0 produces no request and costs one cycle in WALK.
- R6: If no element is active, `opnd_rd` never rises, no request is issued, and `done` is high in the second cycle after `cmd_start` is sampled.
- R7: The hint is decoded as follows: bit 3 drives `req_write` (0 = read, 1 = write), bits 2:1 drive `req_level`, and bit 0 drives `req_stream`.
- R8: A base register number of 31 selects `opnd_sp`. Any other number selects `opnd_gpr`.
- R9: Elements are visited in ascending order from 0, and `req_elem` gives the index of the element being requested.
- R10: A request with `req_ready` low stays valid with an unchanged address. The walk advances past an active element only on a completed handshake.
- R11: `done` is a single-cycle pulse in the cycle after the last element is handled.
- R12: `busy` is high in every state except IDLE. `cmd_start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Starts a command when idle |
| cmd_wide | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| cmd_off64 | input | 1 | Full 64-bit unsigned offsets (applies to 64-bit elements only) |
| cmd_sext | input | 1 | Sign-extend 32-bit offsets |
| cmd_hint | input | 4 | Prefetch hint |
| cmd_basereg | input | 5 | Base register number (31 selects the stack pointer) |
| cmd_pred | input | VLEN/32 | Predicate, one bit per 32-bit slot |
| busy | output | 1 | Command in progress |
| opnd_rd | output | 1 | Operand read strobe; operands are sampled at the end of this cycle |
| opnd_gpr | input | 64 | General register value |
| opnd_sp | input | 64 | Stack pointer value |
| opnd_vec | input | VLEN | Index vector |
| req_valid | output | 1 | Prefetch request valid |
| req_ready | input | 1 | Prefetch request accepted |
| req_addr | output | 64 | Prefetch address |
| req_elem | output | log2(VLEN/32) | Element index of the request |
| req_write | output | 1 | Prefetch for write |
| req_level | output | 2 | Target cache level |
| req_stream | output | 1 | Streaming (non-temporal) access |
| done | output | 1 | Walk finished pulse |

## Verification
Take the clock edge that samples `cmd_start` as edge 0. CHECK occupies the cycle after edge 0. Then either `done` appears after edge 1, or `opnd_rd` appears after edge 1 and the operands are taken at edge 2. The first request can appear after edge 2. Each later element follows one cycle after the previous element is handled, and `done` follows the final element by one cycle. The bench keeps a behavioural model that is advanced at each rising edge, with the inputs driven just after that edge. It compares every output against the model at the falling edge, so each result is checked in exactly the cycle it is due, stalls included.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

    localparam int unsigned ADDR_W = 64;
    localparam int unsigned SLOT_W = 32;
    localparam int unsigned HINT_W = 4;
    localparam int unsigned REG_W  = 5;
    localparam logic [REG_W-1:0] SP_REGNUM = 5'd31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WALK,
        ST_FIN
    } gpf_state_e;

    typedef struct packed {
        logic       write;
        logic [1:0] level;
        logic       stream;
    } gpf_hint_t;

    function automatic gpf_hint_t decode_hint(input logic [HINT_W-1:0] h);
        gpf_hint_t r;
        r.write  = h[3];
        r.level  = h[2:1];
        r.stream = h[0];
        return r;
    endfunction

endpackage

// File: rtl/gpf_elem_pick.sv
module gpf_elem_pick #(
    parameter int unsigned VLEN = 256
) (
    input  logic [VLEN-1:0]                        vec,
    input  logic                                   wide,
    input  logic [$clog2(VLEN/gpf_pkg::SLOT_W)-1:0] idx,
    output logic [gpf_pkg::ADDR_W-1:0]             raw
);
    import gpf_pkg::*;

    localparam int unsigned NSLOT = VLEN / SLOT_W;
    localparam int unsigned NDW   = NSLOT / 2;
    localparam int unsigned DCW   = (NDW > 1) ? $clog2(NDW) : 1;

    logic [SLOT_W-1:0] words [NSLOT];
    logic [ADDR_W-1:0] dwords[NDW];

    for (genvar w = 0; w < NSLOT; w++) begin : g_word
        assign words[w] = vec[w*SLOT_W +: SLOT_W];
    end

    for (genvar d = 0; d < NDW; d++) begin : g_dword
        assign dwords[d] = vec[d*ADDR_W +: ADDR_W];
    end

    always_comb begin
        if (wide) begin
            raw = dwords[idx[DCW-1:0]];
        end else begin
            raw = {{(ADDR_W-SLOT_W){1'b0}}, words[idx]};
        end
    end

endmodule

// File: rtl/gpf_pred_unit.sv
module gpf_pred_unit #(
    parameter int unsigned NSLOT = 8
) (
    input  logic [NSLOT-1:0]         pred,
    input  logic                     wide,
    input  logic [$clog2(NSLOT)-1:0] idx,
    output logic                     elem_act,
    output logic                     any_act
);
    logic [NSLOT-1:0] even_mask;
    logic [NSLOT-1:0] wide_bits;

    for (genvar s = 0; s < NSLOT; s++) begin : g_mask
        assign even_mask[s] = (s % 2 == 0);
    end

    assign wide_bits = pred & even_mask;

    always_comb begin
        if (wide) begin
            any_act  = |wide_bits;
            elem_act = pred[{idx[$clog2(NSLOT)-2:0], 1'b0}];
        end else begin
            any_act  = |pred;
            elem_act = pred[idx];
        end
    end

endmodule

// File: rtl/gpf_addr_calc.sv
module gpf_addr_calc (
    input  logic [gpf_pkg::ADDR_W-1:0] base,
    input  logic [gpf_pkg::ADDR_W-1:0] raw,
    input  logic                       full64,
    input  logic                       sext,
    output logic [gpf_pkg::ADDR_W-1:0] addr
);
    import gpf_pkg::*;

    logic [ADDR_W-1:0] ext;
    logic [ADDR_W-1:0] scaled;

    always_comb begin
        if (full64) begin
            ext = raw;
        end else if (sext) begin
            ext = {{(ADDR_W-SLOT_W){raw[SLOT_W-1]}}, raw[SLOT_W-1:0]};
        end else begin
            ext = {{(ADDR_W-SLOT_W){1'b0}}, raw[SLOT_W-1:0]};
        end
        scaled = {ext[ADDR_W-3:0], 2'b00};
        addr   = base + scaled;
    end

endmodule

// File: rtl/gather_pf_agen.sv
module gather_pf_agen #(
    parameter int unsigned VLEN = 256
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cmd_start,
    input  logic                                   cmd_wide,
    input  logic                                   cmd_off64,
    input  logic                                   cmd_sext,
    input  logic [gpf_pkg::HINT_W-1:0]             cmd_hint,
    input  logic [gpf_pkg::REG_W-1:0]              cmd_basereg,
    input  logic [VLEN/gpf_pkg::SLOT_W-1:0]        cmd_pred,
    output logic                                   busy,
    output logic                                   opnd_rd,
    input  logic [gpf_pkg::ADDR_W-1:0]             opnd_gpr,
    input  logic [gpf_pkg::ADDR_W-1:0]             opnd_sp,
    input  logic [VLEN-1:0]                        opnd_vec,
    output logic                                   req_valid,
    input  logic                                   req_ready,
    output logic [gpf_pkg::ADDR_W-1:0]             req_addr,
    output logic [$clog2(VLEN/gpf_pkg::SLOT_W)-1:0] req_elem,
    output logic                                   req_write,
    output logic [1:0]                             req_level,
    output logic                                   req_stream,
    output logic                                   done
);
    import gpf_pkg::*;

    localparam int unsigned NSLOT = VLEN / SLOT_W;
    localparam int unsigned ECW   = $clog2(NSLOT);
    localparam logic [ECW-1:0] LAST_NARROW = ECW'(NSLOT - 1);
    localparam logic [ECW-1:0] LAST_WIDE   = ECW'(NSLOT / 2 - 1);

    gpf_state_e        st_q, st_d;
    logic              wide_q, off64_q, sext_q, use_sp_q;
    gpf_hint_t         hint_q;
    logic [NSLOT-1:0]  pred_q;
    logic [ADDR_W-1:0] base_q;
    logic [VLEN-1:0]   vec_q;
    logic [ECW-1:0]    eidx_q;

    logic              elem_act, any_act;
    logic [ADDR_W-1:0] raw_idx;
    logic [ADDR_W-1:0] elem_addr;
    logic              at_last;
    logic              advance;

    gpf_pred_unit #(.NSLOT(NSLOT)) u_pred (
        .pred    (pred_q),
        .wide    (wide_q),
        .idx     (eidx_q),
        .elem_act(elem_act),
        .any_act (any_act)
    );

    gpf_elem_pick #(.VLEN(VLEN)) u_pick (
        .vec (vec_q),
        .wide(wide_q),
        .idx (eidx_q),
        .raw (raw_idx)
    );

    gpf_addr_calc u_addr (
        .base  (base_q),
        .raw   (raw_idx),
        .full64(wide_q & off64_q),
        .sext  (sext_q),
        .addr  (elem_addr)
    );

    assign at_last = (eidx_q == (wide_q ? LAST_WIDE : LAST_NARROW));
    assign advance = (st_q == ST_WALK) && (!elem_act || req_ready);

    // State register and captured command/operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            wide_q   <= 1'b0;
            off64_q  <= 1'b0;
            sext_q   <= 1'b0;
            use_sp_q <= 1'b0;
            hint_q   <= '0;
            pred_q   <= '0;
            base_q   <= '0;
            vec_q    <= '0;
            eidx_q   <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && cmd_start) begin
                wide_q   <= cmd_wide;
                off64_q  <= cmd_off64;
                sext_q   <= cmd_sext;
                use_sp_q <= (cmd_basereg == SP_REGNUM);
                hint_q   <= decode_hint(cmd_hint);
                pred_q   <= cmd_pred;
            end
            if (st_q == ST_READ) begin
                base_q <= use_sp_q ? opnd_sp : opnd_gpr;
                vec_q  <= opnd_vec;
                eidx_q <= '0;
            end else if (advance && !at_last) begin
                eidx_q <= eidx_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cmd_start) st_d = ST_CHECK;
            ST_CHECK: st_d = any_act ? ST_READ : ST_FIN;
            ST_READ:  st_d = ST_WALK;
            ST_WALK:  if (advance && at_last) st_d = ST_FIN;
            ST_FIN:   st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b1;
        opnd_rd   = 1'b0;
        req_valid = 1'b0;
        done      = 1'b0;
        unique case (st_q)
            ST_IDLE:  busy      = 1'b0;
            ST_CHECK: ;
            ST_READ:  opnd_rd   = 1'b1;
            ST_WALK:  req_valid = elem_act;
            ST_FIN:   done      = 1'b1;
            default:  busy      = 1'b0;
        endcase
        req_addr   = elem_addr;
        req_elem   = eidx_q;
        req_write  = hint_q.write;
        req_level  = hint_q.level;
        req_stream = hint_q.stream;
    end

    // R10: a stalled request holds its address
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_elem));

    // R11: done lasts exactly one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the operand read is only issued when some element is active
    a_r6_read_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_rd |-> any_act);

    // R6: the operand read is a single-cycle strobe followed by walking
    a_r6_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_rd |=> !opnd_rd && busy);

    // R1: scaling by 4 keeps the base's two low bits
    a_r1_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[1:0] == base_q[1:0]);

    // R9: the next request after a handshake has a higher element index
    a_r9_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid || (req_elem > $past(req_elem)));

    // R12: requests and done never occur while idle
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid && !done && !opnd_rd);

endmodule

// File: tb/gather_pf_agen_tb.sv
module gather_pf_agen_tb;
    localparam int VLEN  = 256;
    localparam int NSLOT = VLEN / 32;
    localparam int ECW   = $clog2(NSLOT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_wide = 1'b0, cmd_off64 = 1'b0, cmd_sext = 1'b0;
    logic [3:0] cmd_hint = '0;
    logic [4:0] cmd_basereg = '0;
    logic [NSLOT-1:0] cmd_pred = '0;
    logic busy, opnd_rd, req_valid, req_write, req_stream, done;
    logic [63:0] opnd_gpr = '0, opnd_sp = '0, req_addr;
    logic [VLEN-1:0] opnd_vec = '0;
    logic req_ready = 1'b1;
    logic [ECW-1:0] req_elem;
    logic [1:0] req_level;

    always #5 clk = ~clk;

    gather_pf_agen #(.VLEN(VLEN)) u_dut (.*);

    int compared = 0, mismatched = 0, cyc = 0, rdy_mode = 0, hs_count = 0;
    bit checking = 0, prev_stall = 0;

    // behavioural model: phase 0 idle,1 check,2 read,3 walk,4 fin
    int mph = 0, me = 0;
    logic mwide, moff64, msext, msp;
    logic [3:0] mhint;
    logic [NSLOT-1:0] mpred;
    logic [63:0] mbase;
    logic [VLEN-1:0] mvec;

    function automatic int m_count();
        return mwide ? NSLOT / 2 : NSLOT;
    endfunction

    function automatic logic m_act(int e);
        return mwide ? mpred[2*e] : mpred[e];
    endfunction

    function automatic logic [63:0] m_addr(int e);
        logic [63:0] v;
        v = mwide ? mvec[e*64 +: 64] : {32'b0, mvec[e*32 +: 32]};
        if (!(mwide && moff64))
            v = msext ? {{32{v[31]}}, v[31:0]} : {32'b0, v[31:0]};
        return mbase + v * 64'd4;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mph = 0;
        end else begin
            case (mph)
                0: if (cmd_start) begin
                    mwide = cmd_wide; moff64 = cmd_off64; msext = cmd_sext;
                    msp = (cmd_basereg == 5'd31); mhint = cmd_hint; mpred = cmd_pred;
                    mph = 1;
                end
                1: begin
                    mph = 4;
                    for (int e = 0; e < m_count(); e++) if (m_act(e)) mph = 2;
                end
                2: begin mbase = msp ? opnd_sp : opnd_gpr; mvec = opnd_vec; me = 0; mph = 3; end
                3: if (!m_act(me) || req_ready) begin
                    if (me == m_count() - 1) mph = 4; else me++;
                end
                default: mph = 0;
            endcase
        end
        if (cyc > 100000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0: req_ready = 1'b1;
            1: req_ready = cyc[0];
            default: req_ready = (cyc % 3 == 0);
        endcase
    end

    always @(negedge clk) begin
        if (checking) begin
            logic ev;
            string t;
            ev = (mph == 3) && m_act(me);
            check("R12 busy", 64'(busy), 64'(mph != 0));
            check("R6 opnd_rd", 64'(opnd_rd), 64'(mph == 2));
            check("R11 done", 64'(done), 64'(mph == 4));
            check("R5 req_valid", 64'(req_valid), 64'(ev));
            if (prev_stall) check("R10 stall held", 64'(req_valid), 64'd1);
            if (ev) begin
                t = (mwide && moff64) ? "R1/R3 addr" : (msp ? "R1/R8 addr" : "R1/R2 addr");
                check(t, req_addr, m_addr(me));
                check("R9 req_elem", 64'(req_elem), 64'(me));
                check("R7 hint", {60'b0, req_write, req_level, req_stream}, {60'b0, mhint});
                if (req_ready) hs_count++;
            end
            prev_stall = req_valid && !req_ready;
        end
    end

    task automatic run_cmd(input logic wide, off64, sext, input logic [3:0] hint,
                           input logic [4:0] breg, input logic [NSLOT-1:0] pred,
                           input int rmode, input bit restart);
        int exp_hs;
        exp_hs = 0;
        for (int e = 0; e < (wide ? NSLOT/2 : NSLOT); e++)
            if (wide ? pred[2*e] : pred[e]) exp_hs++;
        hs_count = 0;
        rdy_mode = rmode;
        @(posedge clk); #1;
        cmd_wide = wide; cmd_off64 = off64; cmd_sext = sext; cmd_hint = hint;
        cmd_basereg = breg; cmd_pred = pred; cmd_start = 1'b1;
        @(posedge clk); #1;
        cmd_start = 1'b0;
        if (restart) begin
            // R12: a second start while busy must be ignored
            @(posedge clk); #1;
            cmd_hint = ~hint; cmd_pred = ~pred; cmd_start = 1'b1;
            @(posedge clk); #1;
            cmd_start = 1'b0;
        end
        while (mph != 0) @(posedge clk);
        @(posedge clk); #1;
        check("R4 request count", 64'(hs_count), 64'(exp_hs));
    endtask

    initial begin
        opnd_gpr = 64'h0000_1000_0000_0103;
        opnd_sp  = 64'hFFFF_FFFF_FFFF_FF02;
        for (int w = 0; w < NSLOT; w++) opnd_vec[w*32 +: 32] = 32'h10 * (w + 1);
        repeat (3) @(posedge clk);
        checking = 1;
        #1;
        check("R12 reset busy", 64'(busy), 64'd0);
        check("R5 reset req_valid", 64'(req_valid), 64'd0);
        check("R11 reset done", 64'(done), 64'd0);
        rst_n = 1'b1;

        // narrow, zero-extend, all active, always ready
        run_cmd(0, 0, 0, 4'b0101, 5'd3, 8'hFF, 0, 0);
        // negative indices: zero- then sign-extended, partial mask, toggling ready
        opnd_vec[31:0] = 32'hFFFF_FFF0; opnd_vec[95:64] = 32'h8000_0000;
        run_cmd(0, 0, 0, 4'b1010, 5'd7, 8'b1010_0101, 1, 0);
        run_cmd(0, 0, 1, 4'b1111, 5'd7, 8'b1010_0101, 1, 0);
        // off64 has no effect with 32-bit elements
        run_cmd(0, 1, 1, 4'b0010, 5'd0, 8'b0000_0101, 0, 0);
        // wide, full 64-bit offsets wrapping, stack pointer base
        opnd_vec[63:0]    = 64'hC000_0000_0000_0001;
        opnd_vec[191:128] = 64'h0000_0001_0000_0000;
        run_cmd(1, 1, 0, 4'b1001, 5'd31, 8'b0101_0101, 2, 0);
        // wide, 32-bit sign-extended offsets, only element 1 active
        run_cmd(1, 0, 1, 4'b0110, 5'd31, 8'b0000_0100, 2, 0);
        // wide with only odd predicate bits: all inactive
        run_cmd(1, 1, 0, 4'b0000, 5'd2, 8'b1010_1010, 0, 0);
        // empty mask
        run_cmd(0, 0, 0, 4'b1000, 5'd1, 8'h00, 0, 0);
        // restart attempt while busy
        run_cmd(0, 0, 1, 4'b0011, 5'd5, 8'b0011_0000, 1, 1);

        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule